// File: doc/BRIEF.md
# Display Output Blanking Generator

This block sits at the end of the video path and decides, for every pixel clock, whether the colour output must be forced to black. It receives the horizontal and vertical beam positions from the beam-timing logic, plus a one-cycle pulse that marks the start of vertical blanking. It also receives a pair of programmable horizontal blank columns, two mode bits and a chip-variant code. From these it produces a blank flag and a flag that marks the extra right-overscan border column.

Three chip variants decode the same two mode bits in different ways:

- **Oldest variant:** always uses fixed hardwired blanking.
- **Middle variant:** can switch blanking almost entirely off. It keeps only a short guard blank in the columns where the horizontal sync pulse sits.
- **Newest variant:** can replace the fixed horizontal window with the programmed start and stop columns.

The variants also differ in how many line ends pass between the vertical-blank pulse and the first blanked line. The block never takes sync as an input. The guard window is a pair of fixed column constants, so blanking and sync remain separate signals.

The mode bits, the programmed columns and the variant code are captured once per line, at the last column. The fixed blank columns, the guard columns and the last vertical-blank line are parameters.

Top module: `disp_blank_gen`

## Requirements
- R1: With variant code 0 (oldest), `blank` is high exactly when `hpos >= HW_HB_START` or `hpos < HW_HB_STOP`, ORed with vertical blanking. The mode bits and programmed columns have no effect.
- R2: With variant codes 1 and 2, the fixed horizontal window starts one column later, at `HW_HB_START+1`. Column `HW_HB_START` is therefore visible when vertical blanking is off.
- R3: With variant 1, `enh_en=1` and `ext_blk_en=0`, `blank` is high only for `SG_START <= hpos < SG_STOP`. Vertical blanking has no effect in this mode.
- R4: With variant 1 and any other mode-bit pair, the fixed window of R2 plus vertical blanking applies. `hb_start` and `hb_stop` have no effect.
- R5: With variant 2 and both mode bits set, horizontal blanking covers `hb_start <= hpos < hb_stop`. When `hb_start > hb_stop` it wraps as `hpos >= hb_start` or `hpos < hb_stop`. When the two are equal there is no horizontal blanking. Vertical blanking still applies.
- R6: With variant 2 and any other mode-bit pair, the fixed window of R2 plus vertical blanking applies. Variant code 3 behaves as code 2.
- R7: For a `vb_strobe` in line N, vertical blanking covers all of line N+1 for variants 0 and 2, and starts at line N+2 for variant 1. It lasts through the whole of the line whose `vpos` equals `VB_END_LINE`.
- R8: A `vb_strobe` given in a mid-screen line blanks the following visible lines completely, with the same latency as R7.
- R9: `variant`, `enh_en`, `ext_blk_en`, `hb_start` and `hb_stop` are sampled only while `hpos == H_TOTAL-1`. They take effect from column 0 of the next line, and a change earlier in a line has no effect on that line.
- R10: `border_only` is high exactly when `blank` is low and `hpos == HW_HB_START`.
- R11: After reset the captured configuration is variant 0 with both mode bits clear and both programmed columns at zero. No vertical blanking is active or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | 9 | Horizontal beam column, 0 to H_TOTAL-1 |
| vpos | input | 9 | Vertical beam line |
| vb_strobe | input | 1 | One-cycle start-of-vertical-blank pulse |
| hb_start | input | 9 | Programmed first blanked column |
| hb_stop | input | 9 | Programmed first visible column after blank |
| enh_en | input | 1 | Enhanced-mode enable bit |
| ext_blk_en | input | 1 | External-blank enable bit |
| variant | input | 2 | Chip variant: 0 oldest, 1 middle, 2 or 3 newest |
| blank | output | 1 | Force colour output to black |
| border_only | output | 1 | Visible extra right-overscan border column |

## Verification
The assertions assume the following about the inputs:

- `hpos` counts upward from 0 to `H_TOTAL-1` and wraps.
- `vb_strobe` is a single-cycle pulse that never lands on the last column of a line.

Every stimulus task follows these rules. The bench drives the beam counters itself, one full line at a time, and places each strobe at a mid-line column.

The bench may jump `vpos` between lines to reach the end-of-blank line without spending whole frames. This is allowed because the block reads `vpos` only as a line value compared at the line end.

// File: rtl/disp_blank_pkg.sv
package disp_blank_pkg;
  localparam int BEAM_W = 9;
  typedef logic [BEAM_W-1:0] beam_t;

  typedef enum logic [1:0] {VAR_OLD = 2'd0, VAR_MID = 2'd1, VAR_NEW = 2'd2} chip_var_e;
  typedef enum logic [1:0] {BM_HARD = 2'd0, BM_PROG = 2'd1, BM_OPEN = 2'd2} blk_mode_e;

  typedef struct packed {
    chip_var_e var_sel;
    logic      enh;
    logic      xblk;
    beam_t     hb_first;
    beam_t     hb_past;
  } line_cfg_t;

  // Half-open column span [first, past); wraps through column 0 when first > past.
  function automatic logic in_span(beam_t pos, beam_t first, beam_t past);
    if (first <= past) return (pos >= first) && (pos < past);
    return (pos >= first) || (pos < past);
  endfunction

  function automatic chip_var_e map_var(logic [1:0] code);
    case (code)
      2'd0:    return VAR_OLD;
      2'd1:    return VAR_MID;
      default: return VAR_NEW;
    endcase
  endfunction

  // Line ends between the strobe and the first blanked line.
  function automatic logic [1:0] vb_lines(chip_var_e v);
    return (v == VAR_MID) ? 2'd2 : 2'd1;
  endfunction

  function automatic blk_mode_e pick_mode(line_cfg_t c);
    case (c.var_sel)
      VAR_MID: return (c.enh && !c.xblk) ? BM_OPEN : BM_HARD;
      VAR_NEW: return (c.enh && c.xblk) ? BM_PROG : BM_HARD;
      default: return BM_HARD;
    endcase
  endfunction
endpackage

// File: rtl/disp_blank_cfg.sv
module disp_blank_cfg
  import disp_blank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_end,
  input  line_cfg_t cfg_in,
  output line_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{var_sel: VAR_OLD, enh: 1'b0, xblk: 1'b0, hb_first: '0, hb_past: '0};
    end else if (line_end) begin
      cfg_q <= cfg_in;
    end
  end
endmodule

// File: rtl/disp_blank_vtrack.sv
module disp_blank_vtrack
  import disp_blank_pkg::*;
#(
  parameter int VB_END_LINE = 25
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_end,
  input  logic      strobe,
  input  beam_t     vpos,
  input  chip_var_e var_sel,
  output logic      vb_active
);
  localparam beam_t END_LINE = beam_t'(VB_END_LINE);

  logic [1:0] lines_left;
  logic [1:0] eff_left;

  always_comb eff_left = strobe ? vb_lines(var_sel) : lines_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vb_active  <= 1'b0;
      lines_left <= '0;
    end else if (line_end) begin
      if (eff_left == 2'd1) begin
        vb_active  <= 1'b1;
        lines_left <= '0;
      end else begin
        if (vpos == END_LINE) vb_active <= 1'b0;
        lines_left <= (eff_left == 2'd0) ? 2'd0 : eff_left - 2'd1;
      end
    end else begin
      lines_left <= eff_left;
    end
  end
endmodule

// File: rtl/disp_blank_hsel.sv
module disp_blank_hsel
  import disp_blank_pkg::*;
#(
  parameter int HW_HB_START = 210,
  parameter int HW_HB_STOP  = 40,
  parameter int SG_START    = 18,
  parameter int SG_STOP     = 34
) (
  input  beam_t     hpos,
  input  line_cfg_t cfg,
  output logic      hw_hblank,
  output logic      prog_hblank,
  output logic      sync_guard
);
  localparam beam_t HW_FIRST_OLD = beam_t'(HW_HB_START);
  localparam beam_t HW_FIRST_EXT = beam_t'(HW_HB_START + 1);
  localparam beam_t HW_PAST      = beam_t'(HW_HB_STOP);
  localparam beam_t SG_FIRST     = beam_t'(SG_START);
  localparam beam_t SG_PAST      = beam_t'(SG_STOP);

  beam_t hw_first;

  always_comb begin
    hw_first    = (cfg.var_sel == VAR_OLD) ? HW_FIRST_OLD : HW_FIRST_EXT;
    hw_hblank   = in_span(hpos, hw_first, HW_PAST);
    prog_hblank = in_span(hpos, cfg.hb_first, cfg.hb_past);
    sync_guard  = in_span(hpos, SG_FIRST, SG_PAST);
  end
endmodule

// File: rtl/disp_blank_gen.sv
module disp_blank_gen
  import disp_blank_pkg::*;
#(
  parameter int H_TOTAL     = 227,
  parameter int HW_HB_START = 210,
  parameter int HW_HB_STOP  = 40,
  parameter int SG_START    = 18,
  parameter int SG_STOP     = 34,
  parameter int VB_END_LINE = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BEAM_W-1:0] hpos,
  input  logic [BEAM_W-1:0] vpos,
  input  logic              vb_strobe,
  input  logic [BEAM_W-1:0] hb_start,
  input  logic [BEAM_W-1:0] hb_stop,
  input  logic              enh_en,
  input  logic              ext_blk_en,
  input  logic [1:0]        variant,
  output logic              blank,
  output logic              border_only
);
  localparam beam_t LINE_LAST  = beam_t'(H_TOTAL - 1);
  localparam beam_t BORDER_COL = beam_t'(HW_HB_START);

  line_cfg_t cfg_in, cfg_q;
  logic      line_end;
  logic      vb_active;
  logic      hw_hblank, prog_hblank, sync_guard;
  blk_mode_e mode;

  always_comb begin
    line_end = (hpos == LINE_LAST);
    cfg_in   = '{var_sel: map_var(variant), enh: enh_en, xblk: ext_blk_en,
                 hb_first: hb_start, hb_past: hb_stop};
  end

  disp_blank_cfg cfg_i (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  disp_blank_vtrack #(.VB_END_LINE(VB_END_LINE)) vtrack_i (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .strobe(vb_strobe),
    .vpos(vpos), .var_sel(cfg_q.var_sel), .vb_active(vb_active)
  );

  disp_blank_hsel #(
    .HW_HB_START(HW_HB_START), .HW_HB_STOP(HW_HB_STOP),
    .SG_START(SG_START), .SG_STOP(SG_STOP)
  ) hsel_i (
    .hpos(hpos), .cfg(cfg_q), .hw_hblank(hw_hblank),
    .prog_hblank(prog_hblank), .sync_guard(sync_guard)
  );

  always_comb begin
    mode = pick_mode(cfg_q);
    case (mode)
      BM_PROG: blank = prog_hblank | vb_active;
      BM_OPEN: blank = sync_guard;
      default: blank = hw_hblank | vb_active;
    endcase
    border_only = !blank && (hpos == BORDER_COL);
  end
endmodule

// File: rtl/disp_blank_chk.sv
module disp_blank_chk
  import disp_blank_pkg::*;
#(
  parameter int HW_HB_START = 210
) (
  input logic      clk,
  input logic      rst_n,
  input beam_t     hpos,
  input logic      line_end,
  input logic      vb_active,
  input blk_mode_e mode,
  input logic      sync_guard,
  input line_cfg_t cfg_q,
  input logic      blank,
  input logic      border_only
);
  localparam beam_t EDGE_COL = beam_t'(HW_HB_START);

  // R7: vertical blanking only begins across a line boundary
  a_r7_vb_rise_on_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vb_active) |-> $past(line_end));

  // R7: active vertical blank forces blank outside the open mode
  a_r7_vb_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_active && mode != BM_OPEN) |-> blank);

  // R9: captured configuration changes only after a line end
  a_r9_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_end) |-> $stable(cfg_q));

  // R3: open mode shows everything outside the guard columns
  a_r3_open_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BM_OPEN && !sync_guard) |-> !blank);

  // R1: oldest variant always blanks the edge column
  a_r1_oldest_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.var_sel == VAR_OLD && hpos == EDGE_COL) |-> blank);

  // R10: border flag never coincides with blank
  a_r10_border_visible: assert property (@(posedge clk) disable iff (!rst_n)
    border_only |-> (!blank && hpos == EDGE_COL));
endmodule

bind disp_blank_gen disp_blank_chk #(.HW_HB_START(HW_HB_START)) chk_i (
  .clk(clk), .rst_n(rst_n), .hpos(hpos), .line_end(line_end),
  .vb_active(vb_active), .mode(mode), .sync_guard(sync_guard), .cfg_q(cfg_q),
  .blank(blank), .border_only(border_only)
);

// File: tb/disp_blank_gen_tb.sv
module disp_blank_gen_tb_top;
  localparam int CLK_P  = 10;
  localparam int HT     = 227;
  localparam int HBS    = 210;
  localparam int HBE    = 40;
  localparam int SGS    = 18;
  localparam int SGE    = 34;
  localparam int VBEND  = 25;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] hpos, vpos, hb_start, hb_stop;
  logic       vb_strobe, enh_en, ext_blk_en;
  logic [1:0] variant;
  logic       blank, border_only;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench reference state
  int m_var, m_s, m_t, m_cnt;
  bit m_e, m_x, m_vb;
  // pending values for mid-line change
  int p_var, p_s, p_t;
  bit p_e, p_x;

  always #(CLK_P/2) clk = ~clk;

  disp_blank_gen #(.H_TOTAL(HT), .HW_HB_START(HBS), .HW_HB_STOP(HBE),
                   .SG_START(SGS), .SG_STOP(SGE), .VB_END_LINE(VBEND)) dut_i (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .vb_strobe(vb_strobe),
    .hb_start(hb_start), .hb_stop(hb_stop), .enh_en(enh_en), .ext_blk_en(ext_blk_en),
    .variant(variant), .blank(blank), .border_only(border_only));

  function automatic bit ref_blank(int v, bit e, bit x, int s, int t, bit vb, int h);
    bit fixed_win;
    bit own_win;
    fixed_win = (h < HBE) || (h >= HBS + ((v == 0) ? 0 : 1));
    if (v == 1 && e && !x) return (h >= SGS) && (h < SGE);
    if (v == 2 && e && x) begin
      if (s == t)     own_win = 1'b0;
      else if (s < t) own_win = (h >= s) && (h < t);
      else            own_win = (h >= s) || (h < t);
      return own_win || vb;
    end
    return fixed_win || vb;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag, input int h, input int l);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s line %0d col %0d: got %0b expected %0b", tag, l, h, act, exp);
    end
  endtask

  task automatic set_cfg(input int v, input bit e, input bit x, input int s, input int t);
    variant = 2'(v); enh_en = e; ext_blk_en = x; hb_start = 9'(s); hb_stop = 9'(t);
  endtask

  // One full line; strobe_col/chg_col < 0 means none.
  task automatic run_line(input int line, input int strobe_col, input int chg_col, input string tag);
    bit exp_b;
    int eff, lat;
    for (int c = 0; c < HT; c++) begin
      @(negedge clk);
      if (c == chg_col) set_cfg(p_var, p_e, p_x, p_s, p_t);
      hpos = 9'(c); vpos = 9'(line); vb_strobe = (c == strobe_col);
      #1;
      exp_b = ref_blank(m_var, m_e, m_x, m_s, m_t, m_vb, c);
      check(blank, exp_b, tag, c, line);
      check(border_only, !exp_b && (c == HBS), {tag, "/R10"}, c, line);
      lat = (m_var == 1) ? 2 : 1;
      eff = vb_strobe ? lat : m_cnt;
      if (c == HT - 1) begin
        if (eff == 1) begin m_vb = 1; m_cnt = 0; end
        else begin
          if (line == VBEND) m_vb = 0;
          m_cnt = (eff > 1) ? eff - 1 : 0;
        end
        m_var = (variant == 2'd3) ? 2 : int'(variant);
        m_e = enh_en; m_x = ext_blk_en; m_s = int'(hb_start); m_t = int'(hb_stop);
      end else m_cnt = eff;
    end
    @(posedge clk); #1;
    vb_strobe = 1'b0;
  endtask

  task automatic clear_vb();
    run_line(VBEND - 1, -1, -1, "R7");
    run_line(VBEND, -1, -1, "R7");
  endtask

  task automatic t_reset();
    // inputs ask for newest programmable mode, but the first line uses the reset capture
    set_cfg(2, 1, 1, 100, 120);
    run_line(50, -1, -1, "R11");
    run_line(51, -1, -1, "R5");
  endtask

  task automatic t_oldest();
    for (int m = 0; m < 4; m++) begin
      set_cfg(0, m[1], m[0], 80, 90);
      run_line(60 + m, -1, -1, "R1");
      run_line(60 + m, -1, -1, "R1");
    end
  endtask

  task automatic t_extended_edge();
    set_cfg(1, 0, 0, 0, 0);
    run_line(70, -1, -1, "R2");
    run_line(71, -1, -1, "R2");
    set_cfg(2, 1, 0, 0, 0);
    run_line(72, -1, -1, "R2");
    run_line(73, -1, -1, "R2");
  endtask

  task automatic t_middle();
    clear_vb();
    set_cfg(1, 1, 0, 100, 150);
    run_line(300, 50, -1, "R3");
    run_line(301, -1, -1, "R3");
    run_line(302, -1, -1, "R3");
    set_cfg(1, 1, 1, 100, 150);
    run_line(303, -1, -1, "R4");
    run_line(304, -1, -1, "R4");
    clear_vb();
    set_cfg(1, 0, 1, 100, 150);
    run_line(80, -1, -1, "R4");
    run_line(81, -1, -1, "R4");
    set_cfg(1, 0, 0, 5, 220);
    run_line(82, -1, -1, "R4");
    run_line(83, -1, -1, "R4");
  endtask

  task automatic t_newest();
    set_cfg(2, 1, 1, 60, 90);
    run_line(90, -1, -1, "R5");
    run_line(91, -1, -1, "R5");
    set_cfg(2, 1, 1, 200, 30);
    run_line(92, -1, -1, "R5");
    set_cfg(2, 1, 1, 70, 70);
    run_line(93, -1, -1, "R5");
    run_line(94, -1, -1, "R5");
    set_cfg(2, 0, 1, 60, 90);
    run_line(95, -1, -1, "R6");
    run_line(96, -1, -1, "R6");
    set_cfg(3, 0, 0, 60, 90);
    run_line(97, -1, -1, "R6");
    set_cfg(3, 1, 1, 60, 90);
    run_line(98, -1, -1, "R6");
    run_line(99, -1, -1, "R6");
  endtask

  task automatic t_vb_latency();
    for (int v = 0; v < 3; v++) begin
      clear_vb();
      set_cfg(v, 0, 0, 0, 0);
      run_line(100, -1, -1, "R7");
      run_line(101, 50, -1, "R7");
      run_line(102, -1, -1, "R7");
      run_line(103, -1, -1, "R7");
      run_line(24, -1, -1, "R7");
      run_line(25, -1, -1, "R7");
      run_line(26, -1, -1, "R7");
    end
  endtask

  task automatic t_vb_visible();
    clear_vb();
    set_cfg(2, 1, 1, 10, 20);
    run_line(149, -1, -1, "R8");
    run_line(150, 120, -1, "R8");
    run_line(151, -1, -1, "R8");
    run_line(152, -1, -1, "R8");
    clear_vb();
  endtask

  task automatic t_line_capture();
    set_cfg(0, 0, 0, 0, 0);
    run_line(160, -1, -1, "R9");
    p_var = 2; p_e = 1; p_x = 1; p_s = 100; p_t = 130;
    run_line(161, -1, 120, "R9");
    run_line(162, -1, -1, "R9");
    p_var = 1; p_e = 1; p_x = 0; p_s = 0; p_t = 0;
    run_line(163, -1, 225, "R9");
    run_line(164, -1, -1, "R9");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_var = 0; m_e = 0; m_x = 0; m_s = 0; m_t = 0; m_vb = 0; m_cnt = 0;
    p_var = 0; p_e = 0; p_x = 0; p_s = 0; p_t = 0;
    rst_n = 1'b0; hpos = '0; vpos = '0; vb_strobe = 1'b0;
    set_cfg(0, 0, 0, 0, 0);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_oldest();
    t_extended_edge();
    t_middle();
    t_newest();
    t_vb_latency();
    t_vb_visible();
    t_line_capture();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule